// File: doc/BRIEF.md
# Indexed Postbyte Address Generator

This unit turns the postbyte of an indexed memory operand into a 16-bit effective address. When `start` is high it captures the postbyte, together with the X, Y, SP and PC values and the two 8-bit accumulators. It then reads as many extension bytes as the postbyte calls for, starting at `pc_val`, which is the address of the byte after the postbyte. The extension bytes arrive over a simple byte-read port. The unit then adds the offset the postbyte selects to the chosen base register.

For the two pointer forms, the sum is not the result. The unit reads a big-endian 16-bit word at that sum, and the word becomes the effective address.

The auto-step forms also report a new value for the base register, with a write-enable and the register index. The surrounding core is expected to store it. One `done` pulse presents all results together, including the number of extension bytes the instruction used.

Top module: `idx_ea_gen`

## Requirements
- R1: While reset is high and after it is released, `done`, `bus_req` and `busy` are low until a `start` is accepted.
- R2: A postbyte with bit 5 clear (form rr0nnnnn) adds the 5-bit signed value in bits 4:0 (-16..+15) to the base register. Bits 7:6 select the base as 00=X, 01=Y, 10=SP, 11=PC. No extension byte is fetched.
- R3: A postbyte of form 111rr00s fetches one extension byte at `pc_val`. It adds the 9-bit signed value {s, byte} to the base selected by bits 4:3, using the same register coding as R2.
- R4: A postbyte of form 111rr010 fetches two extension bytes, the high byte at `pc_val` and the low byte at `pc_val`+1. It adds the resulting 16-bit value to the base.
- R5: When PC is the base, the base value is `pc_val` plus the number of extension bytes. All address arithmetic wraps modulo 65536.
- R6: A postbyte of form 111rr011 fetches a 16-bit offset as in R4 and forms the sum. It then reads a high byte at the sum and a low byte at sum+1, and that word is the effective address.
- R7: A postbyte of form 111rr1aa with aa=00, 01 or 10 adds A, B or D={A,B} to the base, as unsigned values. No byte is fetched.
- R8: A postbyte of form 111rr111 forms the pointer base+D. It reads the word there as in R6, with an extension count of 0.
- R9: A postbyte of form rr1pnnnn, other than 111xxxxx, steps the base by nnnn. The codes 0000..0111 give +1..+8 and 1000..1111 give -8..-1. With p=0 the effective address is the stepped value; with p=1 it is the original value. In both cases `wb_en`=1, `wb_reg`=rr and `wb_value` is the stepped value.
- R10: Every postbyte beginning 111 decodes as one of the R3/R4/R6/R7/R8 forms, never as an auto-step. For all forms except R9, `wb_en` is 0, so PC is never written back.
- R11: `done` is a one-cycle pulse. It rises in the second cycle after the clock edge that accepted `start`, or after the edge that completed the last byte transfer. `ext_count` then holds 0, 1 or 2, and `ea` holds the result.
- R12: While `bus_req` is high and `bus_rvalid` is low, `bus_addr` holds steady. A `start` while `busy` is ignored, and so are changes to the register inputs after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new address computation (taken only when idle) |
| postbyte | input | 8 | Indexed-mode postbyte |
| x_val | input | 16 | X register value |
| y_val | input | 16 | Y register value |
| sp_val | input | 16 | SP register value |
| pc_val | input | 16 | Address of the byte following the postbyte |
| acc_a | input | 8 | Accumulator A |
| acc_b | input | 8 | Accumulator B |
| bus_req | output | 1 | Byte read request |
| bus_addr | output | 16 | Byte read address |
| bus_rdata | input | 8 | Byte read data |
| bus_rvalid | input | 1 | Read data valid; transfer completes at an edge with `bus_req` high |
| busy | output | 1 | A computation is in progress |
| done | output | 1 | One-cycle result strobe |
| ea | output | 16 | Effective address |
| ext_count | output | 2 | Extension bytes consumed |
| wb_en | output | 1 | Base register write-back enable |
| wb_reg | output | 2 | Register to write back (00=X, 01=Y, 10=SP) |
| wb_value | output | 16 | Value to write back |

## Verification
A transfer completes at the edge where `bus_req` and `bus_rvalid` are both high. The reference model therefore answers each request after a varying wait, and it checks `bus_addr` against its queue of expected addresses in the cycle it raises `bus_rvalid`.

`done` and the result fields are due two edges after the accepting edge, or two edges after the last transfer. The model counts those edges down and samples at the falling edge that follows the second one. At every other sampled cycle it expects `done` to be low.

// File: rtl/idx_ea_pkg.sv
package idx_ea_pkg;

  typedef enum logic [2:0] {
    FM_K5,
    FM_K9,
    FM_K16,
    FM_KIND,
    FM_ACC,
    FM_DIND,
    FM_STEP
  } form_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_EXT,
    ST_IND,
    ST_CALC
  } state_e;

  typedef struct packed {
    form_e      form;
    logic [1:0] rsel;
    logic [1:0] n_ext;
    logic       indirect;
    logic       post;
  } pb_dec_t;

endpackage

// File: rtl/idx_pb_decode.sv
module idx_pb_decode
  import idx_ea_pkg::*;
(
  input  logic [7:0] pb,
  output pb_dec_t    dec
);

  always_comb begin
    dec          = '0;
    dec.form     = FM_K5;
    dec.rsel     = pb[7:6];
    if (pb[7:5] == 3'b111) begin
      dec.rsel = pb[4:3];
      if (!pb[2]) begin
        if (!pb[1]) begin
          dec.form  = FM_K9;
          dec.n_ext = 2'd1;
        end else if (!pb[0]) begin
          dec.form  = FM_K16;
          dec.n_ext = 2'd2;
        end else begin
          dec.form     = FM_KIND;
          dec.n_ext    = 2'd2;
          dec.indirect = 1'b1;
        end
      end else if (pb[1:0] == 2'b11) begin
        dec.form     = FM_DIND;
        dec.indirect = 1'b1;
      end else begin
        dec.form = FM_ACC;
      end
    end else if (pb[5]) begin
      dec.form = FM_STEP;
      dec.post = pb[4];
    end
  end

endmodule

// File: rtl/idx_addr_calc.sv
module idx_addr_calc
  import idx_ea_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  pb_dec_t           dec,
  input  logic [7:0]        pb,
  input  logic [ADDR_W-1:0] x_q,
  input  logic [ADDR_W-1:0] y_q,
  input  logic [ADDR_W-1:0] sp_q,
  input  logic [ADDR_W-1:0] pc_q,
  input  logic [7:0]        a_q,
  input  logic [7:0]        b_q,
  input  logic [7:0]        ext_hi,
  input  logic [7:0]        ext_lo,
  output logic [ADDR_W-1:0] sum,
  output logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] mod_val
);

  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] off;
  logic [ADDR_W-1:0] dacc;

  assign dacc = ADDR_W'({a_q, b_q});

  always_comb begin
    unique case (dec.rsel)
      2'd0:    base = x_q;
      2'd1:    base = y_q;
      2'd2:    base = sp_q;
      default: base = pc_q + ADDR_W'(dec.n_ext);
    endcase
  end

  always_comb begin
    unique case (dec.form)
      FM_K5:   off = ADDR_W'($signed(pb[4:0]));
      FM_K9:   off = ADDR_W'($signed({pb[0], ext_hi}));
      FM_K16,
      FM_KIND: off = ADDR_W'({ext_hi, ext_lo});
      FM_ACC: begin
        unique case (pb[1:0])
          2'b00:   off = ADDR_W'(a_q);
          2'b01:   off = ADDR_W'(b_q);
          default: off = dacc;
        endcase
      end
      FM_DIND: off = dacc;
      FM_STEP: off = pb[3] ? ADDR_W'($signed(pb[3:0]))
                           : ADDR_W'({1'b0, pb[3:0]}) + ADDR_W'(1);
      default: off = '0;
    endcase
  end

  assign sum     = base + off;
  assign mod_val = sum;
  assign addr    = (dec.form == FM_STEP && dec.post) ? base : sum;

endmodule

// File: rtl/idx_ea_gen.sv
module idx_ea_gen
  import idx_ea_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [7:0]        postbyte,
  input  logic [ADDR_W-1:0] x_val,
  input  logic [ADDR_W-1:0] y_val,
  input  logic [ADDR_W-1:0] sp_val,
  input  logic [ADDR_W-1:0] pc_val,
  input  logic [7:0]        acc_a,
  input  logic [7:0]        acc_b,
  output logic              bus_req,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_rdata,
  input  logic              bus_rvalid,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] ea,
  output logic [1:0]        ext_count,
  output logic              wb_en,
  output logic [1:0]        wb_reg,
  output logic [ADDR_W-1:0] wb_value
);

  state_e            st;
  logic [7:0]        pb_q;
  logic [ADDR_W-1:0] x_q, y_q, sp_q, pc_q;
  logic [7:0]        a_q, b_q;
  logic [7:0]        ext_hi_q, ext_lo_q, ind_hi_q, ind_lo_q;
  logic              idx_q;
  logic [7:0]        pb_sel;
  pb_dec_t           dec;
  logic [ADDR_W-1:0] calc_sum, calc_addr, calc_mod;
  logic              hs;

  assign pb_sel = (st == ST_IDLE) ? postbyte : pb_q;

  idx_pb_decode u_dec (
    .pb  (pb_sel),
    .dec (dec)
  );

  idx_addr_calc #(.ADDR_W(ADDR_W)) u_calc (
    .dec     (dec),
    .pb      (pb_q),
    .x_q     (x_q),
    .y_q     (y_q),
    .sp_q    (sp_q),
    .pc_q    (pc_q),
    .a_q     (a_q),
    .b_q     (b_q),
    .ext_hi  (ext_hi_q),
    .ext_lo  (ext_lo_q),
    .sum     (calc_sum),
    .addr    (calc_addr),
    .mod_val (calc_mod)
  );

  assign bus_req  = (st == ST_EXT) || (st == ST_IND);
  assign bus_addr = (st == ST_EXT) ? pc_q + ADDR_W'(idx_q) : calc_sum + ADDR_W'(idx_q);
  assign busy     = (st != ST_IDLE);
  assign hs       = bus_req && bus_rvalid;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      pb_q      <= '0;
      x_q       <= '0;
      y_q       <= '0;
      sp_q      <= '0;
      pc_q      <= '0;
      a_q       <= '0;
      b_q       <= '0;
      ext_hi_q  <= '0;
      ext_lo_q  <= '0;
      ind_hi_q  <= '0;
      ind_lo_q  <= '0;
      idx_q     <= 1'b0;
      done      <= 1'b0;
      ea        <= '0;
      ext_count <= '0;
      wb_en     <= 1'b0;
      wb_reg    <= '0;
      wb_value  <= '0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            pb_q  <= postbyte;
            x_q   <= x_val;
            y_q   <= y_val;
            sp_q  <= sp_val;
            pc_q  <= pc_val;
            a_q   <= acc_a;
            b_q   <= acc_b;
            idx_q <= 1'b0;
            if (dec.n_ext != 2'd0)  st <= ST_EXT;
            else if (dec.indirect)  st <= ST_IND;
            else                    st <= ST_CALC;
          end
        end
        ST_EXT: begin
          if (hs) begin
            if (!idx_q) ext_hi_q <= bus_rdata;
            else        ext_lo_q <= bus_rdata;
            if ({1'b0, idx_q} + 2'd1 == dec.n_ext) begin
              idx_q <= 1'b0;
              st    <= dec.indirect ? ST_IND : ST_CALC;
            end else begin
              idx_q <= 1'b1;
            end
          end
        end
        ST_IND: begin
          if (hs) begin
            if (!idx_q) begin
              ind_hi_q <= bus_rdata;
              idx_q    <= 1'b1;
            end else begin
              ind_lo_q <= bus_rdata;
              idx_q    <= 1'b0;
              st       <= ST_CALC;
            end
          end
        end
        default: begin
          ea        <= dec.indirect ? ADDR_W'({ind_hi_q, ind_lo_q}) : calc_addr;
          ext_count <= dec.n_ext;
          wb_en     <= (dec.form == FM_STEP);
          wb_reg    <= dec.rsel;
          wb_value  <= calc_mod;
          done      <= 1'b1;
          st        <= ST_IDLE;
        end
      endcase
    end
  end

  // R11: the result strobe lasts a single cycle
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R11: extension count never exceeds two
  p_ext_range_r11: assert property (@(posedge clk) disable iff (rst)
    done |-> ext_count != 2'd3);

  // R12: an unanswered request keeps its address
  p_addr_hold_r12: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_rvalid |=> bus_req && $stable(bus_addr));

  // R12: a start during a computation leaves the captured postbyte alone
  p_start_ignored_r12: assert property (@(posedge clk) disable iff (rst)
    busy && start |=> $stable(pb_q));

  // R10: program counter is never the write-back target
  p_no_pc_wb_r10: assert property (@(posedge clk) disable iff (rst)
    done && wb_en |-> wb_reg != 2'b11);

  // R1: no request is issued without a computation in progress
  p_req_busy_r1: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> busy);

endmodule

// File: tb/idx_ea_gen_test.sv
module idx_ea_gen_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  postbyte = '0;
  logic [15:0] x_val = '0, y_val = '0, sp_val = '0, pc_val = '0;
  logic [7:0]  acc_a = '0, acc_b = '0;
  logic        bus_req;
  logic [15:0] bus_addr;
  logic [7:0]  bus_rdata = '0;
  logic        bus_rvalid = 1'b0;
  logic        busy, done, wb_en;
  logic [15:0] ea, wb_value;
  logic [1:0]  ext_count, wb_reg;

  int errs = 0;
  int checks = 0;
  int waitgen = 0;

  always #10 clk = ~clk;

  idx_ea_gen uut (
    .clk(clk), .rst(rst), .start(start), .postbyte(postbyte),
    .x_val(x_val), .y_val(y_val), .sp_val(sp_val), .pc_val(pc_val),
    .acc_a(acc_a), .acc_b(acc_b),
    .bus_req(bus_req), .bus_addr(bus_addr), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .busy(busy), .done(done), .ea(ea), .ext_count(ext_count),
    .wb_en(wb_en), .wb_reg(wb_reg), .wb_value(wb_value)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int memb(int a);
    logic [15:0] w;
    logic [7:0]  r;
    w = a[15:0];
    r = w[7:0] * 8'd37;
    r = r ^ w[15:8] ^ 8'h5A;
    return int'(r);
  endfunction

  task automatic run(string tag, logic [7:0] pb, int xv, int yv, int spv, int pcv,
                     int av, int bv, bit poke);
    int rr, ext, base, off, sum, eexp, wbv, due, wt, cyc, e0, e1;
    bit ind, step, post, fin;
    int q[$];
    ext = 0; ind = 0; step = 0; post = 0;
    e0 = memb(pcv); e1 = memb(pcv + 1);
    if (pb[7:5] == 3'b111) begin
      rr = pb[4:3];
      if (!pb[2]) begin
        ext = pb[1] ? 2 : 1;
        ind = pb[1] & pb[0];
        off = pb[1] ? e0 * 256 + e1 : (pb[0] ? e0 - 256 : e0);
      end else begin
        ind = (pb[1:0] == 2'b11);
        off = (pb[1:0] == 2'b00) ? av : (pb[1:0] == 2'b01) ? bv : av * 256 + bv;
      end
    end else if (!pb[5]) begin
      rr = pb[7:6];
      off = pb[4] ? int'(pb[4:0]) - 32 : int'(pb[4:0]);
    end else begin
      rr = pb[7:6]; step = 1; post = pb[4];
      off = pb[3] ? int'(pb[3:0]) - 16 : int'(pb[3:0]) + 1;
    end
    base = (rr == 0) ? xv : (rr == 1) ? yv : (rr == 2) ? spv : pcv + ext;
    base = base & 16'hFFFF;
    sum = (base + off) & 16'hFFFF;
    wbv = sum;
    for (int i = 0; i < ext; i++) q.push_back((pcv + i) & 16'hFFFF);
    if (ind) begin
      q.push_back(sum);
      q.push_back((sum + 1) & 16'hFFFF);
      eexp = memb(sum) * 256 + memb(sum + 1);
    end else begin
      eexp = (step && post) ? base : sum;
    end

    @(negedge clk);
    postbyte = pb; x_val = xv[15:0]; y_val = yv[15:0]; sp_val = spv[15:0];
    pc_val = pcv[15:0]; acc_a = av[7:0]; acc_b = bv[7:0]; start = 1'b1;
    due = (q.size() == 0) ? 2 : -1;
    wt = waitgen % 3; waitgen++;
    cyc = 0; fin = 0;
    while (!fin) begin
      @(negedge clk);
      start = 1'b0; cyc++;
      if (poke && cyc == 2) begin
        start = 1'b1; postbyte = 8'h00; x_val = ~x_val; acc_a = ~acc_a;
      end
      if (due > 0) due--;
      if (due == 0) begin
        chk("R11", "done strobe", done, 1);
        chk(tag, "ea", ea, eexp);
        chk("R11", "ext_count", ext_count, ext);
        chk(step ? "R9" : "R10", "wb_en", wb_en, step);
        if (step) begin
          chk("R9", "wb_reg", wb_reg, rr);
          chk("R9", "wb_value", wb_value, wbv);
        end
        fin = 1;
      end else begin
        chk("R11", "done early", done, 0);
      end
      if (bus_req) begin
        if (q.size() == 0) begin
          chk("R12", "unexpected request", 1, 0);
          bus_rvalid = 1'b0;
        end else if (wt == 0) begin
          chk(tag, "bus_addr", bus_addr, q[0]);
          bus_rdata = memb(bus_addr)[7:0];
          bus_rvalid = 1'b1;
          void'(q.pop_front());
          if (q.size() == 0) due = 2;
          wt = waitgen % 3; waitgen++;
        end else begin
          bus_rvalid = 1'b0;
          wt--;
        end
      end else begin
        bus_rvalid = 1'b0;
      end
      if (cyc > 400) begin
        chk(tag, "watchdog expired", 1, 0);
        fin = 1;
      end
    end
    bus_rvalid = 1'b0;
    @(negedge clk);
    chk("R11", "done clear after strobe", done, 0);
    chk("R12", "idle after result", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "done in reset", done, 0);
    chk("R1", "bus_req in reset", bus_req, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "done after reset", done, 0);
    chk("R1", "bus_req after reset", bus_req, 0);
    chk("R1", "busy after reset", busy, 0);

    run("R2", 8'h0F, 16'h1000, 16'h2000, 16'h3000, 16'h4000, 8'h11, 8'h22, 0);
    run("R2", 8'h50, 16'h1000, 16'h2000, 16'h3000, 16'h4000, 8'h11, 8'h22, 0);
    run("R2", 8'h9F, 16'h1000, 16'h2000, 16'h0000, 16'h4000, 8'h11, 8'h22, 0);
    run("R5", 8'hC5, 16'h1000, 16'h2000, 16'h3000, 16'hFFFD, 8'h11, 8'h22, 0);
    run("R3", 8'hE0, 16'h1234, 16'h2000, 16'h3000, 16'h4000, 8'h11, 8'h22, 0);
    run("R3", 8'hE9, 16'h1000, 16'h0040, 16'h3000, 16'h4100, 8'h11, 8'h22, 0);
    run("R4", 8'hF2, 16'h1000, 16'h2000, 16'hABCD, 16'h4200, 8'h11, 8'h22, 0);
    run("R5", 8'hFA, 16'h1000, 16'h2000, 16'h3000, 16'hFFFF, 8'h11, 8'h22, 0);
    run("R6", 8'hE3, 16'h5555, 16'h2000, 16'h3000, 16'h4300, 8'h11, 8'h22, 0);
    run("R6", 8'hFB, 16'h1000, 16'h2000, 16'h3000, 16'h0800, 8'h11, 8'h22, 0);
    run("R7", 8'hE4, 16'h1000, 16'h2000, 16'h3000, 16'h4000, 8'hF0, 8'h22, 0);
    run("R7", 8'hED, 16'h1000, 16'hFFF0, 16'h3000, 16'h4000, 8'h11, 8'hF3, 0);
    run("R7", 8'hF6, 16'h1000, 16'h2000, 16'h8000, 16'h4000, 8'h91, 8'h22, 0);
    run("R8", 8'hE7, 16'h0100, 16'h2000, 16'h3000, 16'h4000, 8'h12, 8'h34, 0);
    run("R8", 8'hFF, 16'h1000, 16'h2000, 16'h3000, 16'h6000, 8'h01, 8'h02, 0);
    run("R9", 8'h20, 16'hFFFF, 16'h2000, 16'h3000, 16'h4000, 8'h11, 8'h22, 0);
    run("R9", 8'h3F, 16'h1000, 16'h2000, 16'h3000, 16'h4000, 8'h11, 8'h22, 0);
    run("R9", 8'h67, 16'h1000, 16'h2000, 16'h3000, 16'h4000, 8'h11, 8'h22, 0);
    run("R9", 8'hA8, 16'h1000, 16'h2000, 16'h0004, 16'h4000, 8'h11, 8'h22, 0);
    run("R9", 8'hB3, 16'h1000, 16'h2000, 16'h3000, 16'h4000, 8'h11, 8'h22, 0);
    run("R10", 8'hF8, 16'h1000, 16'h2000, 16'h3000, 16'h7000, 8'h11, 8'h22, 0);
    run("R12", 8'hF2, 16'h1000, 16'h2000, 16'h3000, 16'h4400, 8'h11, 8'h22, 1);
    run("R12", 8'hEF, 16'h1000, 16'h2000, 16'h3000, 16'h4000, 8'h20, 8'h00, 1);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL R11 global watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule